// File: doc/BRIEF.md
# Counter Byte Access Port

This block sits between an 8-bit register bus and one 16-bit down-counter channel. Software programs the channel through a command port and a data port. A command byte picks how the 16-bit value is split across byte transfers: low byte only, high byte only, or low byte then high byte. The data port then assembles reload values from those writes and hands a finished reload value to the counter together with a one-cycle completion pulse. While a two-byte reload is half written, a flag tells the counter to hold its count.

A command byte with a zero access field takes a snapshot of the live count. The next two data reads return that frozen value, low byte first, so software gets a consistent pair of bytes while the counter keeps running. In low-then-high mode, a single byte pointer is shared by data writes and unlatched data reads. Software must therefore not interleave the two.

Top module: `cntByteAccess`

## Requirements
- R1: After reset, reloadValue is 0, partialWrite and reloadDone are low, the access mode is low-then-high with the byte pointer on the low byte, no snapshot is held, and rdData shows the low byte of liveCount.
- R2: A command byte whose bits 7:6 differ from parameter CHAN_ID has no effect on mode, pointer, snapshot, reloadValue or partialWrite.
- R3: In low-then-high mode (command bits 5:4 = 11), the first data write stores the low byte and raises partialWrite on the next cycle without changing reloadValue. The second write sets reloadValue to {second, first} and clears partialWrite.
- R4: In low-only mode (bits 5:4 = 01), each data write sets reloadValue to {8'h00, byte}.
- R5: In high-only mode (bits 5:4 = 10), each data write sets reloadValue to {byte, 8'h00}.
- R6: reloadDone is high for exactly the cycle after each write that completes a reload value, in any mode, and is low at all other times.
- R7: A matching command with bits 5:4 = 00 captures liveCount at that clock edge. The next data read returns the snapshot's low byte and the following read returns its high byte, whatever liveCount does in between.
- R8: While a snapshot has not been fully read, further snapshot commands are ignored. After the second read, reads follow liveCount again.
- R9: A matching command with a non-zero access field sets the mode, returns the byte pointer to the low byte, drops any held snapshot, and clears partialWrite, discarding a half-written low byte.
- R10: Unlatched reads return liveCount's low byte in low-only mode and its high byte in high-only mode. In low-then-high mode they alternate low then high.
- R11: In low-then-high mode the byte pointer is shared, so a read following a single low-byte write returns the high byte of liveCount and returns the pointer to the low byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdWr | input | 1 | Command byte strobe |
| cmdData | input | 8 | Command byte: [7:6] channel, [5:4] access, [3:0] unused here |
| dataWr | input | 1 | Data port write strobe |
| dataRd | input | 1 | Data port read strobe (read data valid in the same cycle) |
| wrData | input | DATA_W | Data port write byte |
| liveCount | input | 2*DATA_W | Running count from the counter |
| reloadValue | output | 2*DATA_W | Assembled reload value |
| partialWrite | output | 1 | High while a low-then-high reload is half written |
| reloadDone | output | 1 | One-cycle pulse when a reload value completes |
| rdData | output | DATA_W | Data port read byte |

## Verification
The assertions check the relationships that hold on every cycle:
- reloadValue, reloadDone and a rising partialWrite only ever follow a data write.
- The completion pulse and the partial flag are never high together.
- A command for another channel leaves the outputs untouched.

Only the bench's scenarios can show the byte-level content: which byte lands where in each mode, that a snapshot stays frozen while liveCount moves, that a second snapshot command is ignored, and how the shared pointer reacts to a read after a half-finished write.

// File: rtl/cntBytePkg.sv
package cntBytePkg;

  typedef enum logic [1:0] {
    ACC_LATCH = 2'b00,
    ACC_LOW   = 2'b01,
    ACC_HIGH  = 2'b10,
    ACC_PAIR  = 2'b11
  } accModeT;

  typedef struct packed {
    logic captureLatch;
    logic holdLow;
    logic loadLowOnly;
    logic loadHighOnly;
    logic loadPair;
    logic readLatched;
    logic readHigh;
  } ctrlStrobeT;

  localparam int CMD_W       = 8;
  localparam int CHAN_HI_BIT = 7;
  localparam int CHAN_LO_BIT = 6;
  localparam int ACC_HI_BIT  = 5;
  localparam int ACC_LO_BIT  = 4;

endpackage

// File: rtl/cntByteCtrl.sv
module cntByteCtrl
  import cntBytePkg::*;
#(
  parameter logic [1:0] CHAN_ID = 2'd0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cmdWr,
  input  logic [CMD_W-1:0] cmdData,
  input  logic             dataWr,
  input  logic             dataRd,
  output ctrlStrobeT       strobe,
  output logic             partialWrite
);

  accModeT accMode;
  logic    bytePtr;
  logic    latchPend;
  logic    latchHi;

  logic    cmdHit;
  accModeT cmdAcc;
  logic    wrActive;
  logic    rdActive;

  assign cmdHit   = cmdWr && (cmdData[CHAN_HI_BIT:CHAN_LO_BIT] == CHAN_ID);
  assign cmdAcc   = accModeT'(cmdData[ACC_HI_BIT:ACC_LO_BIT]);
  assign wrActive = !cmdHit && dataWr;
  assign rdActive = !cmdHit && !dataWr && dataRd;

  always_comb begin
    strobe              = '0;
    strobe.captureLatch = cmdHit && (cmdAcc == ACC_LATCH) && !latchPend;
    strobe.loadLowOnly  = wrActive && (accMode == ACC_LOW);
    strobe.loadHighOnly = wrActive && (accMode == ACC_HIGH);
    strobe.holdLow      = wrActive && (accMode == ACC_PAIR) && !bytePtr;
    strobe.loadPair     = wrActive && (accMode == ACC_PAIR) && bytePtr;
    strobe.readLatched  = latchPend;
    if (latchPend) strobe.readHigh = latchHi;
    else           strobe.readHigh = (accMode == ACC_HIGH) ||
                                     ((accMode == ACC_PAIR) && bytePtr);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      accMode      <= ACC_PAIR;
      bytePtr      <= 1'b0;
      latchPend    <= 1'b0;
      latchHi      <= 1'b0;
      partialWrite <= 1'b0;
    end else if (cmdHit) begin
      if (cmdAcc == ACC_LATCH) begin
        if (!latchPend) begin
          latchPend <= 1'b1;
          latchHi   <= 1'b0;
        end
      end else begin
        accMode      <= cmdAcc;
        bytePtr      <= 1'b0;
        latchPend    <= 1'b0;
        latchHi      <= 1'b0;
        partialWrite <= 1'b0;
      end
    end else if (wrActive && (accMode == ACC_PAIR)) begin
      bytePtr      <= !bytePtr;
      partialWrite <= !bytePtr;
    end else if (rdActive) begin
      if (latchPend) begin
        if (latchHi) begin
          latchPend <= 1'b0;
          latchHi   <= 1'b0;
        end else begin
          latchHi   <= 1'b1;
        end
      end else if (accMode == ACC_PAIR) begin
        bytePtr <= !bytePtr;
      end
    end
  end

endmodule

// File: rtl/cntByteData.sv
module cntByteData
  import cntBytePkg::*;
#(
  parameter int DATA_W = 8,
  localparam int CNT_W = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobeT        strobe,
  input  logic [DATA_W-1:0] wrData,
  input  logic [CNT_W-1:0]  liveCount,
  output logic [CNT_W-1:0]  reloadValue,
  output logic              reloadDone,
  output logic [DATA_W-1:0] rdData
);

  logic [DATA_W-1:0] lowHold;
  logic [CNT_W-1:0]  latchVal;
  logic [CNT_W-1:0]  readSrc;
  logic              anyLoad;

  assign anyLoad = strobe.loadLowOnly || strobe.loadHighOnly || strobe.loadPair;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lowHold     <= '0;
      latchVal    <= '0;
      reloadValue <= '0;
      reloadDone  <= 1'b0;
    end else begin
      reloadDone <= anyLoad;
      if (strobe.captureLatch) latchVal <= liveCount;
      if (strobe.holdLow)      lowHold  <= wrData;
      if (strobe.loadLowOnly)       reloadValue <= {{DATA_W{1'b0}}, wrData};
      else if (strobe.loadHighOnly) reloadValue <= {wrData, {DATA_W{1'b0}}};
      else if (strobe.loadPair)     reloadValue <= {wrData, lowHold};
    end
  end

  assign readSrc = strobe.readLatched ? latchVal : liveCount;
  assign rdData  = strobe.readHigh ? readSrc[CNT_W-1:DATA_W] : readSrc[DATA_W-1:0];

endmodule

// File: rtl/cntByteAccess.sv
module cntByteAccess
  import cntBytePkg::*;
#(
  parameter int         DATA_W  = 8,
  parameter logic [1:0] CHAN_ID = 2'd0,
  localparam int        CNT_W   = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdWr,
  input  logic [7:0]        cmdData,
  input  logic              dataWr,
  input  logic              dataRd,
  input  logic [DATA_W-1:0] wrData,
  input  logic [CNT_W-1:0]  liveCount,
  output logic [CNT_W-1:0]  reloadValue,
  output logic              partialWrite,
  output logic              reloadDone,
  output logic [DATA_W-1:0] rdData
);

  ctrlStrobeT strobe;

  cntByteCtrl #(.CHAN_ID(CHAN_ID)) u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .cmdWr        (cmdWr),
    .cmdData      (cmdData),
    .dataWr       (dataWr),
    .dataRd       (dataRd),
    .strobe       (strobe),
    .partialWrite (partialWrite)
  );

  cntByteData #(.DATA_W(DATA_W)) u_data (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .wrData      (wrData),
    .liveCount   (liveCount),
    .reloadValue (reloadValue),
    .reloadDone  (reloadDone),
    .rdData      (rdData)
  );

endmodule

// File: rtl/cntByteAccessChk.sv
module cntByteAccessChk #(
  parameter int         DATA_W  = 8,
  parameter logic [1:0] CHAN_ID = 2'd0,
  localparam int        CNT_W   = 2 * DATA_W
) (
  input logic              clk,
  input logic              rstN,
  input logic              cmdWr,
  input logic [7:0]        cmdData,
  input logic              dataWr,
  input logic              dataRd,
  input logic [CNT_W-1:0]  reloadValue,
  input logic              partialWrite,
  input logic              reloadDone
);

  // R6: a completion pulse only follows a data write
  p_done_after_write_r6: assert property (@(posedge clk) disable iff (!rstN)
    reloadDone |-> $past(dataWr));

  // R3: reload value moves only after a data write
  p_reload_stable_r3: assert property (@(posedge clk) disable iff (!rstN)
    !$past(dataWr) |-> $stable(reloadValue));

  // R3: partial flag rises only after a data write
  p_partial_rise_r3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(partialWrite) |-> $past(dataWr));

  // R3: completing a pair leaves no partial flag
  p_done_excl_partial_r3: assert property (@(posedge clk) disable iff (!rstN)
    reloadDone |-> !partialWrite);

  // R2: foreign-channel command alone changes nothing visible
  p_foreign_cmd_r2: assert property (@(posedge clk) disable iff (!rstN)
    (cmdWr && (cmdData[7:6] != CHAN_ID) && !dataWr && !dataRd)
      |=> ($stable(partialWrite) && $stable(reloadValue) && !reloadDone));

endmodule

bind cntByteAccess cntByteAccessChk #(.DATA_W(DATA_W), .CHAN_ID(CHAN_ID)) u_chk (
  .clk          (clk),
  .rstN         (rstN),
  .cmdWr        (cmdWr),
  .cmdData      (cmdData),
  .dataWr       (dataWr),
  .dataRd       (dataRd),
  .reloadValue  (reloadValue),
  .partialWrite (partialWrite),
  .reloadDone   (reloadDone)
);

// File: tb/cntByteAccess_bench.sv
`timescale 1ns/1ps
module cntByteAccess_bench;

  localparam int         DATA_W = 8;
  localparam int         CNT_W  = 16;
  localparam logic [1:0] CHAN   = 2'd1;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              cmdWr = 1'b0;
  logic [7:0]        cmdData = '0;
  logic              dataWr = 1'b0;
  logic              dataRd = 1'b0;
  logic [DATA_W-1:0] wrData = '0;
  logic [CNT_W-1:0]  liveCount = 16'hA5C3;
  logic [CNT_W-1:0]  reloadValue;
  logic              partialWrite;
  logic              reloadDone;
  logic [DATA_W-1:0] rdData;

  int compared = 0;
  int mismatched = 0;
  bit finished = 0;

  // bench model state
  logic [1:0]  mMode = 2'b11;
  logic        mPtr = 0;
  logic [7:0]  mLo = 0;
  logic [15:0] mRel = 0;
  logic        mPart = 0;
  logic        mLp = 0;
  logic        mLh = 0;
  logic [15:0] mLv = 0;
  logic        mDone = 0;

  always #2 clk = ~clk;

  cntByteAccess #(.DATA_W(DATA_W), .CHAN_ID(CHAN)) u_cntByteAccess (
    .clk(clk), .rstN(rstN), .cmdWr(cmdWr), .cmdData(cmdData),
    .dataWr(dataWr), .dataRd(dataRd), .wrData(wrData), .liveCount(liveCount),
    .reloadValue(reloadValue), .partialWrite(partialWrite),
    .reloadDone(reloadDone), .rdData(rdData)
  );

  task automatic check(input string req, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] expRead(input logic [15:0] live);
    if (mLp) return mLh ? mLv[15:8] : mLv[7:0];
    case (mMode)
      2'b01:   return live[7:0];
      2'b10:   return live[15:8];
      default: return mPtr ? live[15:8] : live[7:0];
    endcase
  endfunction

  function automatic string wrReq(input logic [1:0] m);
    case (m)
      2'b01:   return "R4";
      2'b10:   return "R5";
      default: return "R3";
    endcase
  endfunction

  // one bus cycle: kind 0 idle, 1 command, 2 write, 3 read
  task automatic step(input int kind, input logic [7:0] d, input logic [15:0] live,
                      input string rdReq);
    string req;
    @(negedge clk);
    liveCount = live;
    cmdWr  = (kind == 1);
    dataWr = (kind == 2);
    dataRd = (kind == 3);
    cmdData = d;
    wrData  = d;
    #1;
    if (kind == 3) check(mLp ? "R7" : rdReq, "rdData", {8'h00, rdData}, {8'h00, expRead(live)});
    req = wrReq(mMode);
    mDone = 0;
    if (kind == 1 && d[7:6] == CHAN) begin
      if (d[5:4] == 2'b00) begin
        if (!mLp) begin mLp = 1; mLh = 0; mLv = live; end
      end else begin
        mMode = d[5:4]; mPtr = 0; mLp = 0; mLh = 0; mPart = 0;
      end
      req = "R9";
    end else if (kind == 1) begin
      req = "R2";
    end else if (kind == 2) begin
      case (mMode)
        2'b01: begin mRel = {8'h00, d}; mDone = 1; end
        2'b10: begin mRel = {d, 8'h00}; mDone = 1; end
        default: begin
          if (!mPtr) begin mLo = d; mPtr = 1; mPart = 1; end
          else begin mRel = {d, mLo}; mPtr = 0; mPart = 0; mDone = 1; end
        end
      endcase
    end else if (kind == 3) begin
      if (mLp) begin
        if (mLh) begin mLp = 0; mLh = 0; end else mLh = 1;
      end else if (mMode == 2'b11) mPtr = ~mPtr;
      req = "R8";
    end
    @(posedge clk);
    #1;
    cmdWr = 0; dataWr = 0; dataRd = 0;
    check(req, "reloadValue", reloadValue, mRel);
    check(req, "partialWrite", {15'd0, partialWrite}, {15'd0, mPart});
    check("R6", "reloadDone", {15'd0, reloadDone}, {15'd0, mDone});
  endtask

  function automatic logic [7:0] cmdByte(input logic [1:0] ch, input logic [1:0] acc);
    return {ch, acc, 4'b0110};
  endfunction

  initial begin
    #200000;
    if (!finished) begin
      mismatched++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    int seed;
    int kind;
    logic [7:0] d;
    seed = 32'h1234;
    void'($urandom(seed));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1;
    #1;
    // R1 reset state
    check("R1", "reloadValue", reloadValue, 16'h0000);
    check("R1", "partialWrite", {15'd0, partialWrite}, 16'd0);
    check("R1", "reloadDone", {15'd0, reloadDone}, 16'd0);
    check("R1", "rdData", {8'h00, rdData}, 16'h00C3);

    // R3 pair write
    step(2, 8'h34, 16'h1111, "R10");
    step(2, 8'h12, 16'h1111, "R10");
    // R11 shared pointer: half write then read returns high byte
    step(2, 8'h77, 16'hBEEF, "R11");
    step(3, 8'h00, 16'hBEEF, "R11");
    step(3, 8'h00, 16'hBEEF, "R11");
    // R2 foreign command while half written
    step(2, 8'h55, 16'h2222, "R10");
    step(1, cmdByte(2'd2, 2'b01), 16'h2222, "R10");
    step(2, 8'h66, 16'h2222, "R10");
    // R9 command discards half write
    step(2, 8'h99, 16'h3333, "R10");
    step(1, cmdByte(CHAN, 2'b11), 16'h3333, "R10");
    step(2, 8'h01, 16'h3333, "R10");
    step(2, 8'h02, 16'h3333, "R10");
    // R7 latch then live moves; R8 second latch ignored
    step(1, cmdByte(CHAN, 2'b00), 16'hC0DE, "R10");
    step(1, cmdByte(CHAN, 2'b00), 16'h4444, "R10");
    step(3, 8'h00, 16'h5555, "R7");
    step(3, 8'h00, 16'h6666, "R7");
    step(3, 8'h00, 16'h7788, "R8");
    step(3, 8'h00, 16'h7788, "R10");
    // R4 and R5
    step(1, cmdByte(CHAN, 2'b01), 16'h9A8B, "R10");
    step(2, 8'hAB, 16'h9A8B, "R10");
    step(2, 8'hCD, 16'h9A8B, "R10");
    step(3, 8'h00, 16'h9A8B, "R10");
    step(1, cmdByte(CHAN, 2'b10), 16'h9A8B, "R10");
    step(2, 8'hEF, 16'h9A8B, "R10");
    step(3, 8'h00, 16'h9A8B, "R10");

    // constrained random mix
    for (int i = 0; i < 4000; i++) begin
      kind = 1 + ($urandom % 3);
      d = 8'($urandom);
      if (kind == 1) d = cmdByte(($urandom % 4 == 0) ? 2'(d[1:0]) : CHAN, 2'($urandom % 4));
      step(kind, d, 16'($urandom), "R10");
    end

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule